// File: doc/BRIEF.md
# Character-Cell Raster Pixel Generator

This block produces the colour index for every pixel of a 256×192 character-mapped picture and for the border around it. The screen is a 32×24 grid of 8×8 cells. Each cell owns a code byte and an attribute byte in video memory. The raster counters from an external timing unit drive the block. While one cell is shown, the block reads the code, the attribute and one pattern row for the next cell through a single synchronous memory read port. It then drives a 3-bit colour index for each pixel.

The attribute byte sets the two colours of its cell and also picks the region the patterns are read from. One attribute bit turns the cell into four solid 4×4 quadrants, which gives a 64×48 coarse picture. A processor can write a register that sets the border colour. It can also read back the attribute byte that was fetched most recently. The pixel stream lags the raster position it belongs to by a fixed 10 clock cycles, and the timing unit is expected to allow for this.

Top module: `chargen_display`

## Requirements
- R1: Raster position (h_pos, v_pos) is active when H_ACT0 ≤ h_pos < H_ACT0+256 and V_ACT0 ≤ v_pos < V_ACT0+192. Active column x and line y fall in cell (x/8, y/8), cell index = (y/8)·32 + x/8. The colour for a position appears on pix_colour exactly 10 clock cycles after the position is presented, provided the raster advances one pixel per clock.
- R2: A colour index is 3 bits, with bit 2 green, bit 1 red and bit 0 blue (0 black … 7 white). In a normal cell, pixel x%8 = k shows pattern bit 7−k, so the leftmost pixel is bit 7. A set bit shows attr[2:0] and a clear bit shows attr[5:3].
- R3: The code byte is read at CODE_BASE+index and the attribute byte at ATTR_BASE+index. The pattern row is read at base + code·8 + (y%8), and the address wraps modulo 2^ADDR_W.
- R4: Attribute bit 6 picks the pattern base: 0 selects PAT_PRI and 1 selects PAT_ALT. PAT_ALT may overlap the code and attribute tables, and the bytes found there are then used as pattern rows.
- R5: With attribute bit 7 set, a cell is drawn as four solid 4×4 quadrants, and the pattern byte has no effect on it.
- R6: In block mode, rows 0–3 of the cell take their colours from the code byte and rows 4–7 take theirs from the attribute byte. Within each byte, bits 2:0 colour columns 0–3 and bits 5:3 colour columns 4–7.
- R7: A one-cycle pulse on border_wr loads border_wdata into the border colour register. Every position outside the active area shows that colour.
- R8: attr_rdback returns the attribute byte most recently fetched for display. While only border positions are scanned, it holds its value.
- R9: While reset is asserted, pix_colour, attr_rdback and the border colour are all 0.
- R10: Each active cell issues three reads (code, then attribute, then pattern) in its first three pixel cycles, with vm_en high. Read data is taken one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_pos | input | POS_W | Horizontal raster position |
| v_pos | input | POS_W | Vertical raster position |
| vm_en | output | 1 | Video memory read strobe |
| vm_addr | output | ADDR_W | Video memory read address |
| vm_rdata | input | 8 | Read data, one cycle after the address |
| border_wr | input | 1 | Border colour write strobe |
| border_wdata | input | 3 | New border colour |
| attr_rdback | output | 8 | Attribute most recently fetched |
| pix_colour | output | 3 | Colour index for the current pixel |

## Verification
The situation hardest to reach is a pattern read from the alternate region. There, the pattern address points back into the code and attribute tables, so a single byte in memory acts as a cell's code or attribute and also as another cell's pattern row. The bench fills all of memory with a position-dependent hash and then writes the tables over it. Cell attributes cycle through normal/primary, normal/alternate, block, and block with the base bit set. A full-frame scan therefore produces these aliased reads next to ordinary ones, and every pixel is compared against a model that reads the same memory image.

// File: rtl/chargen_pkg.sv
package chargen_pkg;
  localparam int CELL_PX = 8;
  localparam int SUB_W   = 3;

  typedef logic [2:0] colour_t;

  // one entry of the display-side delay line
  typedef struct packed {
    logic             act;
    logic             upper;
    logic [SUB_W-1:0] sub;
  } tap_t;
endpackage

// File: rtl/chargen_raster.sv
module chargen_raster
  import chargen_pkg::*;
#(
  parameter int POS_W  = 10,
  parameter int H_ACT0 = 48,
  parameter int V_ACT0 = 24,
  parameter int COLS   = 32,
  parameter int ROWS   = 24,
  parameter int IDX_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] h_pos,
  input  logic [POS_W-1:0] v_pos,
  output logic             f_act,
  output logic [SUB_W-1:0] f_sub,
  output logic [2:0]       f_row,
  output logic [IDX_W-1:0] f_idx,
  output tap_t             d_tap
);
  localparam int H_SPAN = COLS * CELL_PX;
  localparam int V_SPAN = ROWS * CELL_PX;
  localparam logic [POS_W-1:0] HLO = POS_W'(H_ACT0);
  localparam logic [POS_W-1:0] HHI = POS_W'(H_ACT0 + H_SPAN);
  localparam logic [POS_W-1:0] VLO = POS_W'(V_ACT0);
  localparam logic [POS_W-1:0] VHI = POS_W'(V_ACT0 + V_SPAN);
  localparam int CELLS = COLS * ROWS;

  logic [POS_W-1:0] ax, ay;
  logic             act_n;
  logic [SUB_W-1:0] sub_n;
  logic [2:0]       row_n;
  logic [IDX_W-1:0] idx_n;
  tap_t             dl   [CELL_PX];
  tap_t             dl_n [CELL_PX];

  // next-state: decode position into cell coordinates
  always_comb begin
    ax    = h_pos - HLO;
    ay    = v_pos - VLO;
    act_n = (h_pos >= HLO) && (h_pos < HHI) && (v_pos >= VLO) && (v_pos < VHI);
    sub_n = ax[SUB_W-1:0];
    row_n = ay[2:0];
    idx_n = IDX_W'(ay[POS_W-1:3]) * IDX_W'(COLS) + IDX_W'(ax[POS_W-1:3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_act <= 1'b0;
      f_sub <= '0;
      f_row <= '0;
      f_idx <= '0;
    end else begin
      f_act <= act_n;
      f_sub <= sub_n;
      f_row <= row_n;
      f_idx <= act_n ? idx_n : '0;
    end
  end

  // delay line: display side runs one cell behind the fetch side
  always_comb begin
    dl_n[0] = '{act: f_act, upper: ~f_row[2], sub: f_sub};
    for (int i = 1; i < CELL_PX; i++) dl_n[i] = dl[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELL_PX; i++) dl[i] <= '0;
    end else begin
      for (int i = 0; i < CELL_PX; i++) dl[i] <= dl_n[i];
    end
  end

  assign d_tap = dl[CELL_PX-1];

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    f_act |-> (int'(f_idx) < CELLS));
endmodule

// File: rtl/chargen_fetch.sv
module chargen_fetch
  import chargen_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IDX_W     = 10,
  parameter int CELLS     = 768,
  parameter int CODE_BASE = 'h100,
  parameter int ATTR_BASE = 'h500,
  parameter int PAT_PRI   = 'h1000,
  parameter int PAT_ALT   = 'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_act,
  input  logic [SUB_W-1:0]  f_sub,
  input  logic [2:0]        f_row,
  input  logic [IDX_W-1:0]  f_idx,
  input  logic [7:0]        vm_rdata,
  output logic              vm_en,
  output logic [ADDR_W-1:0] vm_addr,
  output logic              cell_load,
  output logic [7:0]        code_q,
  output logic [7:0]        attr_q,
  output logic [7:0]        pat_q
);
  localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(CODE_BASE);
  localparam logic [ADDR_W-1:0] A_ATTR = ADDR_W'(ATTR_BASE);
  localparam logic [ADDR_W-1:0] A_PRI  = ADDR_W'(PAT_PRI);
  localparam logic [ADDR_W-1:0] A_ALT  = ADDR_W'(PAT_ALT);

  logic code_en, attr_en, pat_en;
  logic [ADDR_W-1:0] pat_base;

  // slot decode: 0 code address, 1 attribute address, 2 pattern address
  always_comb begin
    code_en   = f_act && (f_sub == 3'd1);
    attr_en   = f_act && (f_sub == 3'd2);
    pat_en    = f_act && (f_sub == 3'd3);
    cell_load = f_act && (f_sub == 3'd7);
    vm_en     = f_act && (f_sub < 3'd3);
    pat_base  = vm_rdata[6] ? A_ALT : A_PRI;
    vm_addr   = '0;
    if (f_act) begin
      case (f_sub)
        3'd0:    vm_addr = A_CODE + ADDR_W'(f_idx);
        3'd1:    vm_addr = A_ATTR + ADDR_W'(f_idx);
        3'd2:    vm_addr = pat_base + ADDR_W'({code_q, 3'b000}) + ADDR_W'(f_row);
        default: vm_addr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      attr_q <= '0;
      pat_q  <= '0;
    end else begin
      if (code_en) code_q <= vm_rdata;
      if (attr_en) attr_q <= vm_rdata;
      if (pat_en)  pat_q  <= vm_rdata;
    end
  end

  p_code_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (f_act && f_sub == 3'd0) |-> (vm_en && (int'(vm_addr - A_CODE) < CELLS)));

  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (f_act && f_sub == 3'd2) |=> (attr_q == $past(vm_rdata)));

  p_rdback_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_act) |=> $stable(attr_q));
endmodule

// File: rtl/chargen_shade.sv
module chargen_shade
  import chargen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_load,
  input  logic [7:0] code_q,
  input  logic [7:0] attr_q,
  input  logic [7:0] pat_q,
  input  tap_t       d_tap,
  input  colour_t    border,
  output colour_t    pix_colour
);
  logic [7:0] dc, da, dp;
  logic [7:0] blk_byte;
  logic       pat_bit;
  colour_t    pix_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc <= '0;
      da <= '0;
      dp <= '0;
    end else if (cell_load) begin
      dc <= code_q;
      da <= attr_q;
      dp <= pat_q;
    end
  end

  always_comb begin
    blk_byte = d_tap.upper ? dc : da;
    pat_bit  = dp[3'd7 - d_tap.sub];
    if (!d_tap.act)     pix_n = border;
    else if (da[7])     pix_n = d_tap.sub[2] ? blk_byte[5:3] : blk_byte[2:0];
    else if (pat_bit)   pix_n = da[2:0];
    else                pix_n = da[5:3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_colour <= '0;
    else        pix_colour <= pix_n;
  end

  p_border_colour_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_tap.act) |=> (pix_colour == $past(border)));

  p_block_flat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tap.act && da[7] && d_tap.sub[1:0] != 2'd0) |=> (pix_colour == $past(pix_colour)));
endmodule

// File: rtl/chargen_display.sv
module chargen_display
  import chargen_pkg::*;
#(
  parameter int POS_W     = 10,
  parameter int H_ACT0    = 48,
  parameter int V_ACT0    = 24,
  parameter int COLS      = 32,
  parameter int ROWS      = 24,
  parameter int ADDR_W    = 13,
  parameter int CODE_BASE = 'h100,
  parameter int ATTR_BASE = 'h500,
  parameter int PAT_PRI   = 'h1000,
  parameter int PAT_ALT   = 'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  h_pos,
  input  logic [POS_W-1:0]  v_pos,
  output logic              vm_en,
  output logic [ADDR_W-1:0] vm_addr,
  input  logic [7:0]        vm_rdata,
  input  logic              border_wr,
  input  logic [2:0]        border_wdata,
  output logic [7:0]        attr_rdback,
  output logic [2:0]        pix_colour
);
  localparam int CELLS = COLS * ROWS;
  localparam int IDX_W = $clog2(CELLS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // border colour register
  colour_t border_q, border_n;
  always_comb border_n = border_wr ? border_wdata : border_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) border_q <= '0;
    else          border_q <= border_n;
  end

  logic             f_act;
  logic [SUB_W-1:0] f_sub;
  logic [2:0]       f_row;
  logic [IDX_W-1:0] f_idx;
  tap_t             d_tap;
  logic             cell_load;
  logic [7:0]       code_q, attr_q, pat_q;

  chargen_raster #(
    .POS_W(POS_W), .H_ACT0(H_ACT0), .V_ACT0(V_ACT0),
    .COLS(COLS), .ROWS(ROWS), .IDX_W(IDX_W)
  ) u_raster (
    .clk(clk), .rst_n(rst_i_n), .h_pos(h_pos), .v_pos(v_pos),
    .f_act(f_act), .f_sub(f_sub), .f_row(f_row), .f_idx(f_idx), .d_tap(d_tap)
  );

  chargen_fetch #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CELLS(CELLS),
    .CODE_BASE(CODE_BASE), .ATTR_BASE(ATTR_BASE),
    .PAT_PRI(PAT_PRI), .PAT_ALT(PAT_ALT)
  ) u_fetch (
    .clk(clk), .rst_n(rst_i_n), .f_act(f_act), .f_sub(f_sub), .f_row(f_row),
    .f_idx(f_idx), .vm_rdata(vm_rdata), .vm_en(vm_en), .vm_addr(vm_addr),
    .cell_load(cell_load), .code_q(code_q), .attr_q(attr_q), .pat_q(pat_q)
  );

  chargen_shade u_shade (
    .clk(clk), .rst_n(rst_i_n), .cell_load(cell_load), .code_q(code_q),
    .attr_q(attr_q), .pat_q(pat_q), .d_tap(d_tap), .border(border_q),
    .pix_colour(pix_colour)
  );

  assign attr_rdback = attr_q;
endmodule

// File: tb/sim_chargen_display.sv
module sim_chargen_display;
  localparam int H_TOTAL = 280;
  localparam int V_TOTAL = 198;
  localparam int HA0 = 8;
  localparam int VA0 = 3;
  localparam int CB = 'h100;
  localparam int AB = 'h500;
  localparam int PP = 'h800;
  localparam int PA = 'h000;
  localparam int LAT = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] h_pos = '0, v_pos = '0;
  logic       vm_en;
  logic [11:0] vm_addr;
  logic [7:0] vm_rdata;
  logic       border_wr = 1'b0;
  logic [2:0] border_wdata = '0;
  logic [7:0] attr_rdback;
  logic [2:0] pix_colour;

  logic [7:0] mem [4096];
  int checks = 0, fails = 0;
  logic [2:0] border_exp = '0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) vm_rdata <= mem[vm_addr];

  chargen_display #(
    .POS_W(10), .H_ACT0(HA0), .V_ACT0(VA0), .COLS(32), .ROWS(24), .ADDR_W(12),
    .CODE_BASE(CB), .ATTR_BASE(AB), .PAT_PRI(PP), .PAT_ALT(PA)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos), .vm_en(vm_en),
    .vm_addr(vm_addr), .vm_rdata(vm_rdata), .border_wr(border_wr),
    .border_wdata(border_wdata), .attr_rdback(attr_rdback), .pix_colour(pix_colour)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of one pixel; tag names the requirement that governs it
  function automatic logic [2:0] model(input int h, input int v, output string tag);
    int ax, ay, idx, sub, r;
    logic [7:0] c, a, p, b;
    ax = h - HA0; ay = v - VA0;
    if (ax < 0 || ax >= 256 || ay < 0 || ay >= 192) begin
      tag = "R7 border";
      return border_exp;
    end
    idx = (ay / 8) * 32 + ax / 8; sub = ax % 8; r = ay % 8;
    c = mem[CB + idx]; a = mem[AB + idx];
    if (a[7]) begin
      tag = "R5/R6 block";
      b = (r < 4) ? c : a;
      return (sub < 4) ? b[2:0] : b[5:3];
    end
    tag = a[6] ? "R4 alt base" : "R2/R3 normal";
    p = mem[((a[6] ? PA : PP) + int'(c) * 8 + r) % 4096];
    return p[7 - sub] ? a[2:0] : a[5:3];
  endfunction

  // scan full lines; R1: output compared LAT cycles after each position
  task automatic scan(input int v0, input int nlines);
    int hh[16], vv[16];
    int total, j;
    string tag;
    logic [2:0] e;
    total = nlines * H_TOTAL;
    for (j = 0; j < total + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        e = model(hh[(j - LAT) % 16], vv[(j - LAT) % 16], tag);
        check(pix_colour == e, $sformatf("R1 %s h=%0d v=%0d", tag,
              hh[(j - LAT) % 16], vv[(j - LAT) % 16]), pix_colour, e);
      end
      if (j < total) begin
        hh[j % 16] = j % H_TOTAL;
        vv[j % 16] = v0 + j / H_TOTAL;
      end else begin
        hh[j % 16] = 0;
        vv[j % 16] = V_TOTAL - 1;
      end
      h_pos = 10'(hh[j % 16]);
      v_pos = 10'(vv[j % 16]);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    h_pos = '0; v_pos = '0;
    repeat (4) @(negedge clk);
    check(pix_colour == 3'd0, "R9 pixel in reset", pix_colour, 0);
    check(attr_rdback == 8'd0, "R9 readback in reset", attr_rdback, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pix_colour == 3'd0, "R9 border reset value", pix_colour, 0);
  endtask

  task automatic set_border(input logic [2:0] c);
    @(negedge clk);
    border_wr = 1'b1; border_wdata = c;
    @(negedge clk);
    border_wr = 1'b0;
    border_exp = c;
  endtask

  // R2..R6, R10: whole frame with mixed cell kinds
  task automatic t_frame;
    set_border(3'd5);
    scan(0, V_TOTAL);
    check(attr_rdback == mem[AB + 767], "R8 readback after frame",
          attr_rdback, mem[AB + 767]);
  endtask

  // R7: border change, then first cell row partly scanned
  task automatic t_border_partial;
    set_border(3'd2);
    scan(0, VA0 + 4);
    check(attr_rdback == mem[AB + 31], "R8 readback after row 0",
          attr_rdback, mem[AB + 31]);
    repeat (20) @(negedge clk);
    check(attr_rdback == mem[AB + 31], "R8 readback held in border",
          attr_rdback, mem[AB + 31]);
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = 8'((k * 29 + 11) ^ (k >> 4));
    for (int i = 0; i < 768; i++) begin
      int m;
      m = i % 4;
      mem[CB + i] = 8'(i * 37 + 5);
      mem[AB + i] = {m >= 2, (m == 1) || (m == 3), 3'((i / 3 + 1) % 8), 3'(i % 8)};
    end
    t_reset;
    t_frame;
    t_border_partial;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule